// File: doc/BRIEF.md
# Serial Flash Shift Engine

This block is the bit-level engine of a single-lane SPI master aimed at serial flash. It pulls 32-bit words from a transmit queue, where each word carries its own count of valid bytes. It shifts those bytes out on a serial clock divided down from the block clock. At the same time it gathers the bytes it receives into 32-bit words and hands them to a receive queue. A set of active-low chip-select lines is driven from a configuration word, and those lines change only while the engine is idle.

Configuration arrives through a simple write port that loads the configuration word. A second write port sets or clears a one-bit global enable. The configuration word holds these fields, by bit position:

- bit 0: master enable
- bit 1: clock polarity
- bit 2: clock phase
- bits [5:3]: divisor exponent
- bits [13:10]: chip-select field
- bit 14: chip-select force
- bit 15: manual-start enable
- bit 16: start trigger, which acts only in the cycle it is written

Bits [9:6] and any bits above 16 have no effect.

The control is one state machine with these states:

- ST_IDLE (waiting)
- ST_FETCH (taking a word from the queue)
- ST_FIRST (first half of a bit)
- ST_SECOND (second half of a bit)
- ST_FLUSH (handing over the received word)

The transitions are:

- IDLE→FETCH on a start condition.
- FETCH→FIRST when a word is accepted, or FETCH→IDLE if the queue has gone empty.
- FIRST→SECOND at the end of a half period.
- SECOND→FIRST for the next bit, or SECOND→FLUSH after the last bit of the word.
- FLUSH→FETCH when another word is waiting, or FLUSH→IDLE when the queue is empty.

Every state except IDLE waits in place while the block is not active.

Top module: `sflash_shift_engine`

## Requirements
- R1: After reset, cs_n is all ones, sclk and mosi are 0, and busy, tx_ready and rx_valid are low. The global enable and every configuration field are cleared, except the chip-select field, which resets to all ones.
- R2: The divisor exponent n (config bits [5:3]) sets each half of a serial clock period to 2^n block clocks. One word of b bytes keeps busy high for 2 + 16·b·2^n cycles, and back-to-back words add up with no gap.
- R3: With clock phase 0 (config bit 2), each bit is presented before the leading edge and sampled on the leading edge. With phase 1, each bit changes on the leading edge and is sampled on the trailing edge.
- R4: The bytes of a word go out least significant byte first, with each byte sent MSB first. tx_nbytes of 1, 2 or 3 sends that many bytes; a value of 0, or above 4, sends all 4.
- R5: A received word carries its b bytes in the top b byte lanes. The first byte received sits in the lowest of those lanes, and the lanes left unfilled are zero. rx_valid pulses for one cycle with rx_nbytes equal to b.
- R6: cs_n comes from config bits [13:10], active low. With force (bit 14) set, cs_n follows the field whenever the engine is idle. With force clear, cs_n carries the field from the start of a burst until the return to idle, and is all ones otherwise.
- R7: cs_n never changes while busy is high.
- R8: With manual start (bit 15) set, a waiting word is not taken until a configuration write with bit 16 set. Words then go out back to back until the queue is empty, and a later word waits for a new start.
- R9: With manual start clear, a word presented while idle is accepted on the second clock edge after it appears.
- R10: While the global enable is 0 or the master bit (config bit 0) is 0, no word is accepted, busy stays low if idle, and a transfer in progress freezes.
- R11: Whenever busy is low, sclk rests at the clock polarity (config bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the serial clock is derived from it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load the configuration word this cycle |
| cfg_data | input | 17 | Configuration word; bit 16 is the start trigger |
| en_wr | input | 1 | Load the global enable this cycle |
| en_bit | input | 1 | New global enable value |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_word | input | 32 | Transmit word |
| tx_nbytes | input | 3 | Valid byte count of tx_word (0 means 4) |
| tx_ready | output | 1 | Word taken at this clock edge |
| rx_valid | output | 1 | Received word ready (one cycle) |
| rx_word | output | 32 | Received word, valid bytes at the top |
| rx_nbytes | output | 3 | Valid byte count of rx_word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |
| busy | output | 1 | Engine not idle |

## Verification
The bench plays the flash side. It samples mosi and drives miso from the serial clock edges alone, so all four clock modes and divisors from 0 to 7 are judged only by what appears on the wire.

The corner cases it targets, and what a faulty design would show:

- Partial words of one to three bytes, and the counts 0 and 6. A wrong count shows up as missing or extra bytes and as a wrong busy length.
- Receive lane placement. A design packing from the wrong end returns the bytes in the low lanes.
- Manual start with the trigger withheld. An engine that ignores it starts early.
- A second burst without a new trigger, which a sticky start would let through.
- Both ways of holding the engine off, each of which must leave it idle.
- Chip select under force and automatic modes. A design that updated it mid-burst, or never released it, fails the per-cycle comparison.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    // Positions of the configuration fields; the software view depends on them.
    localparam int CFG_MASTER   = 0;
    localparam int CFG_CPOL     = 1;
    localparam int CFG_CPHA     = 2;
    localparam int CFG_DIV_LSB  = 3;
    localparam int CFG_CS_LSB   = 10;
    localparam int CFG_CS_FORCE = 14;
    localparam int CFG_MAN_EN   = 15;
    localparam int CFG_MAN_GO   = 16;
    localparam int CFG_W        = 17;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FIRST,
        ST_SECOND,
        ST_FLUSH
    } sfe_state_e;

endpackage

// File: rtl/sfe_half_timer.sv
// Counts block clocks inside one half of a serial clock period.
module sfe_half_timer #(
    parameter int DIV_W = 3,
    localparam int CNT_W = 2 ** DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div_exp,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = (CNT_W'(1) << div_exp) - CNT_W'(1);
        tick  = run && (cnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || tick) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/sfe_tx_bitsel.sv
// Picks the outgoing bit: byte lanes in rising order, each byte MSB first.
module sfe_tx_bitsel #(
    parameter int BYTES = 4,
    localparam int WORD_W = 8 * BYTES,
    localparam int BIT_W  = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [BIT_W-1:0]  bit_idx,
    output logic              bit_out
);

    logic [BIT_W-1:0] pos;

    always_comb begin
        // Same lane, bit order inside the lane reversed.
        pos     = bit_idx ^ BIT_W'(7);
        bit_out = word[pos];
    end

endmodule

// File: rtl/sfe_rx_pack.sv
// Gathers sampled bits into bytes and pushes each byte in at the top lane.
module sfe_rx_pack #(
    parameter int BYTES = 4,
    localparam int WORD_W = 8 * BYTES,
    localparam int BIT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              din,
    output logic [WORD_W-1:0] word
);

    logic [6:0]        part_q;
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_q <= '0;
            word_q <= '0;
        end else if (clear) begin
            word_q <= '0;
        end else if (sample) begin
            if (bit_idx[2:0] == 3'd7) begin
                word_q <= {part_q, din, word_q[WORD_W-1:8]};
            end else begin
                part_q <= {part_q[5:0], din};
            end
        end
    end

    assign word = word_q;

endmodule

// File: rtl/sflash_shift_engine.sv
module sflash_shift_engine
    import sfe_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int DIV_W  = 3,
    parameter int BYTES  = 4,
    localparam int WORD_W = 8 * BYTES,
    localparam int BIT_W  = $clog2(WORD_W),
    localparam int NB_W   = $clog2(BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              en_wr,
    input  logic              en_bit,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [NB_W-1:0]   tx_nbytes,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_word,
    output logic [NB_W-1:0]   rx_nbytes,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    output logic              busy
);

    // Configuration fields
    logic              master_q, cpol_q, cpha_q, force_q, man_q;
    logic [DIV_W-1:0]  div_q;
    logic [NUM_CS-1:0] csf_q;
    logic              en_q;
    logic              start_pend_q;
    logic              unused_cfg;

    // Engine state
    sfe_state_e        state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic [NB_W-1:0]   nbytes_q;
    logic [BIT_W-1:0]  bit_q;
    logic [NUM_CS-1:0] cs_q;

    logic              active, go, tick, last_bit, tx_bit;
    logic [NB_W-1:0]   nb_eff;
    logic [NB_W+2:0]   last_full;
    logic              in_bit;
    logic              cpol_w, active_w;

    assign unused_cfg = ^cfg_data[CFG_CS_LSB-1:CFG_DIV_LSB+DIV_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_q <= 1'b0;
            cpol_q   <= 1'b0;
            cpha_q   <= 1'b0;
            div_q    <= '0;
            csf_q    <= '1;
            force_q  <= 1'b0;
            man_q    <= 1'b0;
        end else if (cfg_wr) begin
            master_q <= cfg_data[CFG_MASTER];
            cpol_q   <= cfg_data[CFG_CPOL];
            cpha_q   <= cfg_data[CFG_CPHA];
            div_q    <= cfg_data[CFG_DIV_LSB +: DIV_W];
            csf_q    <= cfg_data[CFG_CS_LSB +: NUM_CS];
            force_q  <= cfg_data[CFG_CS_FORCE];
            man_q    <= cfg_data[CFG_MAN_EN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (en_wr) begin
            en_q <= en_bit;
        end
    end

    always_comb begin
        active    = en_q && master_q;
        go        = active && tx_valid && (!man_q || start_pend_q);
        in_bit    = (state_q == ST_FIRST) || (state_q == ST_SECOND);
        nb_eff    = ((tx_nbytes == '0) || (tx_nbytes > NB_W'(BYTES))) ? NB_W'(BYTES) : tx_nbytes;
        last_full = {nbytes_q, 3'b000} - (NB_W+3)'(1);
        last_bit  = (bit_q == last_full[BIT_W-1:0]);
    end

    sfe_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q == ST_FETCH),
        .run     (active && in_bit),
        .div_exp (div_q),
        .tick    (tick)
    );

    sfe_tx_bitsel #(.BYTES(BYTES)) u_txsel (
        .word    (word_q),
        .bit_idx (bit_q),
        .bit_out (tx_bit)
    );

    sfe_rx_pack #(.BYTES(BYTES)) u_rxpack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q == ST_FETCH),
        .sample  ((state_q == ST_FIRST) && tick),
        .bit_idx (bit_q),
        .din     (miso),
        .word    (rx_word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (active) state_d = tx_valid ? ST_FIRST : ST_IDLE;
            end
            ST_FIRST: begin
                if (tick) state_d = ST_SECOND;
            end
            ST_SECOND: begin
                if (tick) state_d = last_bit ? ST_FLUSH : ST_FIRST;
            end
            ST_FLUSH: begin
                if (active) state_d = tx_valid ? ST_FETCH : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Word, bit counter, start request and chip select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q       <= '0;
            nbytes_q     <= NB_W'(BYTES);
            bit_q        <= '0;
            start_pend_q <= 1'b0;
            cs_q         <= '1;
        end else begin
            if (cfg_wr && cfg_data[CFG_MAN_GO]) begin
                start_pend_q <= 1'b1;
            end else if ((state_q == ST_IDLE) && go) begin
                start_pend_q <= 1'b0;
            end

            if (state_q == ST_IDLE) begin
                cs_q <= (force_q || go) ? csf_q : '1;
            end

            if ((state_q == ST_FETCH) && active && tx_valid) begin
                word_q   <= tx_word;
                nbytes_q <= nb_eff;
                bit_q    <= '0;
            end else if ((state_q == ST_SECOND) && tick && !last_bit) begin
                bit_q <= bit_q + BIT_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        sclk      = cpol_q ^ (((state_q == ST_FIRST) && cpha_q) ||
                              ((state_q == ST_SECOND) && !cpha_q));
        mosi      = in_bit ? tx_bit : 1'b0;
        tx_ready  = (state_q == ST_FETCH) && active && tx_valid;
        rx_valid  = (state_q == ST_FLUSH) && active;
        rx_nbytes = nbytes_q;
        cs_n      = cs_q;
        busy      = (state_q != ST_IDLE);
        cpol_w    = cpol_q;
        active_w  = active;
    end

endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
    parameter int NUM_CS = 4,
    parameter int NB_W   = 3,
    parameter int BYTES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [NUM_CS-1:0] cs_n,
    input logic              sclk,
    input logic              cpol,
    input logic              active,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic [NB_W-1:0]   rx_nbytes
);

    AST_CS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_n)) else $error("cs_n moved while busy"); // R7

    AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol)) else $error("sclk not at rest level"); // R11

    AST_TAKE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (tx_valid && busy)) else $error("word taken with none offered"); // R4

    AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid) else $error("rx_valid longer than one cycle"); // R5

    AST_RX_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_nbytes != '0) && (rx_nbytes <= NB_W'(BYTES)))) else $error("bad rx count"); // R5

    AST_HALT_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!tx_ready && !rx_valid)) else $error("activity while halted"); // R10

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !active && !$past(active)) |-> ($stable(sclk) && $stable(busy))) else $error("halted engine moved"); // R10

endmodule

bind sflash_shift_engine sfe_checker #(.NUM_CS(NUM_CS), .NB_W(NB_W), .BYTES(BYTES)) u_sfe_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .cpol      (cpol_w),
    .active    (active_w),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .rx_valid  (rx_valid),
    .rx_nbytes (rx_nbytes)
);

// File: tb/sflash_shift_engine_test.sv
`timescale 1ns/1ps
module sflash_shift_engine_test;

    localparam int NUM_CS = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [16:0]       cfg_data = '0;
    logic              en_wr = 1'b0;
    logic              en_bit = 1'b0;
    logic              tx_valid = 1'b0;
    logic [31:0]       tx_word = '0;
    logic [2:0]        tx_nbytes = '0;
    logic              tx_ready, rx_valid, sclk, mosi, busy;
    logic              miso = 1'b0;
    logic [31:0]       rx_word;
    logic [2:0]        rx_nbytes;
    logic [NUM_CS-1:0] cs_n;

    always #10 clk = ~clk;

    sflash_shift_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .en_wr(en_wr), .en_bit(en_bit), .tx_valid(tx_valid), .tx_word(tx_word),
        .tx_nbytes(tx_nbytes), .tx_ready(tx_ready), .rx_valid(rx_valid),
        .rx_word(rx_word), .rx_nbytes(rx_nbytes), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .busy(busy)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Flash-side model state
    bit          m_cpol, m_cpha, armed;
    logic        prev_sclk;
    int          sb, busy_cycles, rx_n, cs_bad;
    logic [7:0]  mos_cap [0:63];
    logic [31:0] rx_cap [0:15];
    logic [2:0]  rx_nbc [0:15];
    logic [NUM_CS-1:0] exp_cs;

    function automatic logic [7:0] miso_byte(input int i);
        return 8'((i * 73 + 29) ^ (i >> 2));
    endfunction

    function automatic int eff_nb(input int n);
        return (n == 0 || n > 4) ? 4 : n;
    endfunction

    always @(negedge clk) begin
        if (rst_n && armed) begin
            if (busy) begin
                busy_cycles++;
                if (cs_n !== exp_cs) cs_bad++;
            end
            if (sclk !== prev_sclk) begin
                // sampling edge: leading for phase 0, trailing for phase 1
                if ((prev_sclk == m_cpol) != m_cpha) begin
                    if ((sb >> 3) < 64) mos_cap[sb >> 3][7 - (sb % 8)] = mosi;
                    sb++;
                    miso = miso_byte(sb >> 3)[7 - (sb % 8)];
                end
            end
            prev_sclk = sclk;
            if (rx_valid && rx_n < 16) begin
                rx_cap[rx_n] = rx_word;
                rx_nbc[rx_n] = rx_nbytes;
                rx_n++;
            end
        end
    end

    task automatic cfg_write(input logic [16:0] d);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_data = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic en_write(input logic v);
        @(negedge clk);
        en_wr = 1'b1;
        en_bit = v;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic arm(input bit cp, input bit ph, input logic [NUM_CS-1:0] csf);
        @(posedge clk);
        #1;
        m_cpol = cp;
        m_cpha = ph;
        prev_sclk = sclk;
        sb = 0;
        busy_cycles = 0;
        rx_n = 0;
        cs_bad = 0;
        exp_cs = csf;
        miso = miso_byte(0)[7];
        armed = 1'b1;
    endtask

    // hold: 0 none, 1 enable off, 2 master off, 3 manual start
    task automatic run_burst(input int nw, input int fnb, input bit cp, input bit ph,
                             input int dv, input bit frc, input logic [NUM_CS-1:0] csf,
                             input int hold);
        logic [31:0] w [0:11];
        int          nb [0:11];
        logic [7:0]  exp_b [0:63];
        int          tot, exp_busy, stuck, waits, bidx;
        logic [16:0] base;
        logic [31:0] e;
        bit          man;
        man  = (hold == 3);
        base = {1'b0, man, frc, csf, 4'b0000, 3'(dv), ph, cp, (hold != 2)};
        if (hold == 1) en_write(1'b0);
        cfg_write(base);
        arm(cp, ph, csf);
        tot = 0;
        exp_busy = 0;
        for (int i = 0; i < nw; i++) begin
            w[i]  = $urandom;
            nb[i] = (fnb < 0) ? int'($urandom_range(0, 4)) : fnb;
            for (int k = 0; k < eff_nb(nb[i]); k++) begin
                exp_b[tot] = w[i][8*k +: 8];
                tot++;
            end
            exp_busy += 2 + 16 * eff_nb(nb[i]) * (1 << dv);
        end
        tx_word = w[0];
        tx_nbytes = 3'(nb[0]);
        tx_valid = 1'b1;
        if (hold != 0) begin
            stuck = 0;
            repeat (25) begin
                @(negedge clk);
                if (busy || tx_ready) stuck++;
            end
            chk(stuck == 0, (hold == 3) ? "R8" : "R10", "engine started while held", 32'(stuck), 32'd0);
            chk(cs_n === (frc ? csf : {NUM_CS{1'b1}}), "R6", "idle cs_n before burst", 32'(cs_n),
                32'(frc ? csf : {NUM_CS{1'b1}}));
            if (hold == 1) en_write(1'b1);
            else if (hold == 2) cfg_write(base | 17'h1);
            else cfg_write(base | 17'h10000);
        end
        for (int i = 0; i < nw; i++) begin
            tx_word = w[i];
            tx_nbytes = 3'(nb[i]);
            tx_valid = 1'b1;
            waits = 0;
            do begin
                @(negedge clk);
                waits++;
            end while (!tx_ready && waits < 100000);
            if (i == 0 && hold == 0)
                chk(waits == 2, "R9", "auto start latency", 32'(waits), 32'd2);
            @(posedge clk);
            #1;
        end
        tx_valid = 1'b0;
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);

        chk(rx_n == nw, "R5", "received word count", 32'(rx_n), 32'(nw));
        bidx = 0;
        for (int i = 0; i < nw && i < rx_n; i++) begin
            e = '0;
            for (int k = 0; k < eff_nb(nb[i]); k++)
                e[(4 - eff_nb(nb[i]) + k) * 8 +: 8] = miso_byte(bidx + k);
            bidx += eff_nb(nb[i]);
            chk(rx_cap[i] === e, "R5", "rx word lanes (R3 mode)", rx_cap[i], e);
            chk(rx_nbc[i] === 3'(eff_nb(nb[i])), "R5", "rx byte count", 32'(rx_nbc[i]), 32'(eff_nb(nb[i])));
        end
        chk(sb == tot * 8, "R4", "bits shifted", 32'(sb), 32'(tot * 8));
        for (int j = 0; j < tot && j < 64; j++)
            chk(mos_cap[j] === exp_b[j], "R4", "mosi byte order (R3 mode)", 32'(mos_cap[j]), 32'(exp_b[j]));
        chk(busy_cycles == exp_busy, "R2", "busy length for divisor", 32'(busy_cycles), 32'(exp_busy));
        chk(sclk === cp, "R11", "sclk rest level", 32'(sclk), 32'(cp));
        chk(cs_n === (frc ? csf : {NUM_CS{1'b1}}), "R6", "cs_n after burst", 32'(cs_n),
            32'(frc ? csf : {NUM_CS{1'b1}}));
        chk(cs_bad == 0, "R7", "cs_n wrong during busy", 32'(cs_bad), 32'd0);

        if (man) begin
            armed = 1'b0;
            tx_word = 32'hA5A5_5A5A;
            tx_nbytes = 3'd1;
            tx_valid = 1'b1;
            stuck = 0;
            repeat (20) begin
                @(negedge clk);
                if (busy || tx_ready) stuck++;
            end
            tx_valid = 1'b0;
            chk(stuck == 0, "R8", "restart without new trigger", 32'(stuck), 32'd0);
        end
        armed = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        armed = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n === '1, "R1", "cs_n in reset", 32'(cs_n), 32'hF);
        chk(sclk === 1'b0 && mosi === 1'b0, "R1", "sclk/mosi in reset", {30'd0, sclk, mosi}, 32'd0);
        chk(busy === 1'b0 && tx_ready === 1'b0 && rx_valid === 1'b0, "R1", "handshakes in reset",
            {29'd0, busy, tx_ready, rx_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n === '1 && busy === 1'b0, "R1", "after reset release", {27'd0, busy, cs_n}, 32'hF);

        en_write(1'b1);
        // Directed corner cases
        run_burst(1, 1, 1'b0, 1'b0, 0, 1'b0, 4'b1110, 0);   // single byte, fastest clock
        run_burst(3, 2, 1'b1, 1'b0, 1, 1'b1, 4'b1101, 0);   // forced select, polarity 1
        run_burst(2, 3, 1'b0, 1'b1, 0, 1'b0, 4'b1011, 1);   // enable held off, phase 1
        run_burst(4, 0, 1'b1, 1'b1, 1, 1'b0, 4'b0111, 3);   // manual start, count 0
        run_burst(2, 6, 1'b0, 1'b0, 2, 1'b1, 4'b1100, 2);   // master off, count above 4
        run_burst(1, 4, 1'b0, 1'b1, 7, 1'b0, 4'b1110, 0);   // slowest divisor
        // Random mix
        for (int r = 0; r < 8; r++) begin
            run_burst(int'($urandom_range(1, 6)), -1, 1'($urandom), 1'($urandom),
                      int'($urandom_range(0, 2)), 1'($urandom), 4'($urandom),
                      int'($urandom_range(0, 3)));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule